// File: doc/BRIEF.md
# Rectangular Frame-Memory Transfer Engine

This block copies a rectangle of 16-bit pixels between a 32-bit word stream and a 1024 by 512 pixel frame memory. A start strobe provides a position word, a size word and a direction flag. In the write direction, words arrive on a valid/ready input stream and are stored one pixel per cycle. In the read direction, pixels are fetched and packed two to a word on a valid/ready output stream.

The engine walks the rectangle row by row. The column offset and the row index are kept across stalls, so a stream that stops in the middle of a row resumes at the same pixel later. When a width is odd, a single word can span two rows. When all pixels are done, a one-cycle done pulse reports the original rectangle, so that a consumer can invalidate any copy it holds of that area.

The frame memory sits outside the block. It is a synchronous single-port RAM with one cycle of read latency.

Top module: `vram_rect_xfer`

## Requirements
- R1: When `start_i` is high, the start column is taken from `pos_i[9:0]` and the start row from `pos_i[24:16]`.
- R2: The width is `((size_i[9:0] - 1) mod 1024) + 1` and the height is `((size_i[24:16] - 1) mod 512) + 1`. An encoded 0 therefore means 1024 columns or 512 rows.
- R3: In the write direction, pixel k of the rectangle is written to address `row*1024 + col`. Even k takes bits 15:0 of a stream word and odd k takes bits 31:16. One pixel is written per cycle, and `s_ready_o` is high only while a write transfer waits for a word.
- R4: Column k mod w is placed at `(x + k mod w) mod 1024`. Row k div w is placed at `(y + k div w) mod 512`.
- R5: Gaps in either stream pause the walk at the current pixel and it resumes there. With an odd width, one word supplies the last pixel of one row and the first pixel of the next row.
- R6: The transfer ends after exactly w*h pixels, and the unused upper half of a final odd word is dropped. `done_o` is then high for one cycle, with `done_x_o`, `done_y_o`, `done_w_o` and `done_h_o` giving the decoded rectangle.
- R7: A read start sets `img_busy_o`, and `img_busy_o` clears in the cycle that `done_o` rises. The first word (the pixels at the start position) is offered on `m_data_o` without waiting for `m_ready_i`. A word stays valid and unchanged until it is accepted.
- R8: If a read ends on an even pixel count k, the final word carries that pixel in bits 15:0 and zero in bits 31:16.
- R9: A start while a transfer is active drops the old transfer without a done pulse, begins the new one, and sets `anomaly_o`. `anomaly_o` then stays set until reset.
- R10: After reset the engine is idle. `busy_o`, `s_ready_o`, `m_valid_o`, `mem_en_o`, `img_busy_o`, `anomaly_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| start_rd_i | input | 1 | Direction at start: 1 = read from memory |
| pos_i | input | 32 | Position word |
| size_i | input | 32 | Size word |
| s_valid_i | input | 1 | Write stream word valid |
| s_data_i | input | 32 | Write stream word |
| s_ready_o | output | 1 | Write stream word accepted |
| m_valid_o | output | 1 | Read stream word valid |
| m_data_o | output | 32 | Read stream word |
| m_ready_i | input | 1 | Read stream consumer ready |
| mem_en_o | output | 1 | Frame memory access enable |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_addr_o | output | 19 | Frame memory pixel address |
| mem_wdata_o | output | 16 | Frame memory write pixel |
| mem_rdata_i | input | 16 | Frame memory read pixel, one cycle after enable |
| busy_o | output | 1 | Transfer in progress |
| img_busy_o | output | 1 | Read transfer in progress |
| anomaly_o | output | 1 | Sticky flag: a start arrived while busy |
| done_o | output | 1 | One-cycle completion pulse |
| done_x_o | output | 10 | Completed rectangle start column |
| done_y_o | output | 9 | Completed rectangle start row |
| done_w_o | output | 11 | Completed rectangle width |
| done_h_o | output | 10 | Completed rectangle height |

## Verification
The bench streams several kinds of rectangle:
- An even-width write with no gaps checks the basic address order and the halfword order.
- An odd-width write placed in the corner that wraps both column and row, fed with idle gaps, separates a correct saved offset from one that restarts at the row's start, and shows words that span two rows.
- A one-column write with full height and a full-width read check the zero encoding and the row wrap.
- Reads with consumer stalls, including a read-back of written pixels and an odd final word, check the preloaded first word, the hold-until-accepted rule and the zeroed upper half.
- An abort test checks that the old transfer gives no done pulse and that the anomaly flag stays set.

// File: rtl/vrx_pkg.sv
`timescale 1ns/1ps
package vrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI,
    ST_RCAP,
    ST_ROUT
  } xfer_st_t;

endpackage

// File: rtl/vrx_decode.sv
`timescale 1ns/1ps
module vrx_decode #(
  parameter int XW   = 10,
  parameter int YW   = 9,
  parameter int FPOS = 16,
  parameter int WW   = 32
) (
  input  logic [WW-1:0] pos_i,
  input  logic [WW-1:0] size_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [XW:0]   w_o,
  output logic [YW:0]   h_o
);

  logic [XW-1:0] wm1;
  logic [YW-1:0] hm1;
  logic          unused_dec;

  always_comb begin
    x_o = pos_i[XW-1:0];
    y_o = pos_i[FPOS +: YW];
    wm1 = size_i[XW-1:0] - XW'(1);
    hm1 = size_i[FPOS +: YW] - YW'(1);
    w_o = {1'b0, wm1} + (XW+1)'(1);
    h_o = {1'b0, hm1} + (YW+1)'(1);
  end

  assign unused_dec = ^{pos_i[FPOS-1:XW], pos_i[WW-1:FPOS+YW],
                        size_i[FPOS-1:XW], size_i[WW-1:FPOS+YW]};

endmodule

// File: rtl/vrx_walker.sv
`timescale 1ns/1ps
module vrx_walker #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [XW-1:0]  x0_i,
  input  logic [YW-1:0]  y0_i,
  input  logic [XW:0]    w_i,
  input  logic [YW:0]    h_i,
  input  logic           step_i,
  output logic [XW+YW-1:0] addr_o,
  output logic           active_o,
  output logic           last_o
);

  logic [XW-1:0] x0_q;
  logic [XW:0]   w_q;
  logic [XW-1:0] off_q;
  logic [YW-1:0] row_q;
  logic [YW:0]   left_q;
  logic          col_end;

  always_comb begin
    col_end  = (({1'b0, off_q} + (XW+1)'(1)) == w_q);
    active_o = (left_q != '0);
    last_o   = active_o && (left_q == (YW+1)'(1)) && col_end;
    addr_o   = {row_q, XW'(x0_q + off_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x0_q   <= '0;
      w_q    <= '0;
      off_q  <= '0;
      row_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      x0_q   <= x0_i;
      w_q    <= w_i;
      off_q  <= '0;
      row_q  <= y0_i;
      left_q <= h_i;
    end else if (step_i && active_o) begin
      if (col_end) begin
        off_q  <= '0;
        row_q  <= row_q + YW'(1);
        left_q <= left_q - (YW+1)'(1);
      end else begin
        off_q <= off_q + XW'(1);
      end
    end
  end

  AST_OFF_BELOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    active_o |-> ({1'b0, off_q} < w_q)); // R5

  AST_ROW_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (step_i && active_o && !load_i && col_end && (row_q == '1)) |=> (row_q == '0)); // R4

  AST_ROWS_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step_i && active_o && !load_i && col_end) |=> (left_q == $past(left_q) - (YW+1)'(1))); // R6

endmodule

// File: rtl/vrx_rd_pack.sv
`timescale 1ns/1ps
module vrx_rd_pack #(
  parameter int PIXW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              hi_zero_i,
  input  logic [PIXW-1:0]   pix_i,
  input  logic              m_ready_i,
  output logic              m_valid_o,
  output logic [2*PIXW-1:0] m_data_o
);

  logic [PIXW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (clr_i) begin
      m_valid_o <= 1'b0;
    end else begin
      if (cap_lo_i) lo_q <= pix_i;
      if (cap_hi_i) begin
        m_data_o  <= {(hi_zero_i ? '0 : pix_i), lo_q};
        m_valid_o <= 1'b1;
      end else if (m_valid_o && m_ready_i) begin
        m_valid_o <= 1'b0;
      end
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i && !clr_i) |=> (m_valid_o && $stable(m_data_o))); // R7

endmodule

// File: rtl/vram_rect_xfer.sv
`timescale 1ns/1ps
module vram_rect_xfer
  import vrx_pkg::*;
#(
  parameter int XW   = 10,
  parameter int YW   = 9,
  parameter int PIXW = 16,
  parameter int FPOS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                start_rd_i,
  input  logic [2*PIXW-1:0]   pos_i,
  input  logic [2*PIXW-1:0]   size_i,
  input  logic                s_valid_i,
  input  logic [2*PIXW-1:0]   s_data_i,
  output logic                s_ready_o,
  output logic                m_valid_o,
  output logic [2*PIXW-1:0]   m_data_o,
  input  logic                m_ready_i,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [XW+YW-1:0]    mem_addr_o,
  output logic [PIXW-1:0]     mem_wdata_o,
  input  logic [PIXW-1:0]     mem_rdata_i,
  output logic                busy_o,
  output logic                img_busy_o,
  output logic                anomaly_o,
  output logic                done_o,
  output logic [XW-1:0]       done_x_o,
  output logic [YW-1:0]       done_y_o,
  output logic [XW:0]         done_w_o,
  output logic [YW:0]         done_h_o
);

  localparam int WW = 2 * PIXW;
  localparam int AW = XW + YW;

  xfer_st_t        state_q;
  logic [PIXW-1:0] hold_q;
  logic            single_q;

  logic [XW-1:0]   dec_x;
  logic [YW-1:0]   dec_y;
  logic [XW:0]     dec_w;
  logic [YW:0]     dec_h;

  logic [AW-1:0]   wk_addr;
  logic            wk_active;
  logic            wk_last;
  logic            wk_step;
  logic            finish;

  vrx_decode #(.XW(XW), .YW(YW), .FPOS(FPOS), .WW(WW)) u_decode (
    .pos_i  (pos_i),
    .size_i (size_i),
    .x_o    (dec_x),
    .y_o    (dec_y),
    .w_o    (dec_w),
    .h_o    (dec_h)
  );

  vrx_walker #(.XW(XW), .YW(YW)) u_walker (
    .clk      (clk),
    .rst      (rst),
    .load_i   (start_i),
    .x0_i     (dec_x),
    .y0_i     (dec_y),
    .w_i      (dec_w),
    .h_i      (dec_h),
    .step_i   (wk_step),
    .addr_o   (wk_addr),
    .active_o (wk_active),
    .last_o   (wk_last)
  );

  vrx_rd_pack #(.PIXW(PIXW)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (start_i),
    .cap_lo_i  (state_q == ST_RHI),
    .cap_hi_i  (state_q == ST_RCAP),
    .hi_zero_i (single_q),
    .pix_i     (mem_rdata_i),
    .m_ready_i (m_ready_i),
    .m_valid_o (m_valid_o),
    .m_data_o  (m_data_o)
  );

  always_comb begin
    wk_step  = 1'b0;
    mem_en_o = 1'b0;
    mem_we_o = 1'b0;
    finish   = 1'b0;
    if (!start_i) begin
      case (state_q)
        ST_WLO: if (s_valid_i) begin
          mem_en_o = 1'b1;
          mem_we_o = 1'b1;
          wk_step  = 1'b1;
          finish   = wk_last;
        end
        ST_WHI: begin
          mem_en_o = 1'b1;
          mem_we_o = 1'b1;
          wk_step  = 1'b1;
          finish   = wk_last;
        end
        ST_RLO: begin
          mem_en_o = 1'b1;
          wk_step  = 1'b1;
        end
        ST_RHI: if (wk_active) begin
          mem_en_o = 1'b1;
          wk_step  = 1'b1;
        end
        ST_ROUT: finish = m_valid_o && m_ready_i && !wk_active;
        default: ;
      endcase
    end
    mem_addr_o  = wk_addr;
    mem_wdata_o = (state_q == ST_WHI) ? hold_q : s_data_i[PIXW-1:0];
    s_ready_o   = (state_q == ST_WLO) && !start_i;
    busy_o      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      hold_q     <= '0;
      single_q   <= 1'b0;
      img_busy_o <= 1'b0;
      anomaly_o  <= 1'b0;
      done_o     <= 1'b0;
      done_x_o   <= '0;
      done_y_o   <= '0;
      done_w_o   <= '0;
      done_h_o   <= '0;
    end else begin
      done_o <= finish;
      if (start_i) begin
        anomaly_o  <= anomaly_o | (state_q != ST_IDLE);
        state_q    <= start_rd_i ? ST_RLO : ST_WLO;
        img_busy_o <= start_rd_i;
        done_x_o   <= dec_x;
        done_y_o   <= dec_y;
        done_w_o   <= dec_w;
        done_h_o   <= dec_h;
      end else begin
        if (finish) img_busy_o <= 1'b0;
        case (state_q)
          ST_WLO: if (s_valid_i) begin
            hold_q  <= s_data_i[WW-1:PIXW];
            state_q <= wk_last ? ST_IDLE : ST_WHI;
          end
          ST_WHI:  state_q <= wk_last ? ST_IDLE : ST_WLO;
          ST_RLO:  state_q <= ST_RHI;
          ST_RHI: begin
            single_q <= !wk_active;
            state_q  <= ST_RCAP;
          end
          ST_RCAP: state_q <= ST_ROUT;
          ST_ROUT: if (m_valid_o && m_ready_i) state_q <= wk_active ? ST_RLO : ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_WRITE_NOT_IN_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !img_busy_o); // R3

  AST_READY_ONLY_WRITING: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> (busy_o && !img_busy_o)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_IMG_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !img_busy_o); // R7

  AST_ANOMALY_STICKY: assert property (@(posedge clk) disable iff (rst)
    anomaly_o |=> anomaly_o); // R9

endmodule

// File: tb/vram_rect_xfer_bench.sv
`timescale 1ns/1ps
module vram_rect_xfer_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, start_rd;
  logic [31:0] pos_in, size_in;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready;
  logic        m_valid;
  logic [31:0] m_data;
  logic        m_ready;
  logic        mem_en, mem_we;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        busy, img_busy, anomaly, done;
  logic [9:0]  done_x;
  logic [8:0]  done_y;
  logic [10:0] done_w;
  logic [9:0]  done_h;

  int checks = 0;
  int fails  = 0;
  int cx, cy, cw, ch, seed;

  logic [34:0] wq[$];
  logic [31:0] rq[$];
  logic [39:0] dq[$];
  logic [15:0] fm [int unsigned];

  always #10 clk = ~clk;

  vram_rect_xfer u_vram_rect_xfer (
    .clk(clk), .rst(rst), .start_i(start), .start_rd_i(start_rd),
    .pos_i(pos_in), .size_i(size_in),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .m_valid_o(m_valid), .m_data_o(m_data), .m_ready_i(m_ready),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .img_busy_o(img_busy), .anomaly_o(anomaly), .done_o(done),
    .done_x_o(done_x), .done_y_o(done_y), .done_w_o(done_w), .done_h_o(done_h)
  );

  function automatic logic [15:0] pat(int unsigned a);
    return 16'((a * 13 + 5) ^ (a >> 7));
  endfunction

  function automatic logic [15:0] peek(int unsigned a);
    if (fm.exists(a)) return fm[a];
    return pat(a);
  endfunction

  function automatic int unsigned pix_addr(int k);
    return int'((cy + k / cw) % 512) * 1024 + int'((cx + k % cw) % 1024);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Frame memory model: one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) fm[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= peek(int'(mem_addr));
    end
  end

  // Scoreboard monitor, sampled mid-cycle
  always @(negedge clk) begin
    logic [34:0] ew;
    logic [31:0] er;
    logic [39:0] ed;
    if (!rst) begin
      if (mem_en && mem_we) begin
        if (wq.size() == 0) check(1'b0, "R3", "unexpected pixel write", {mem_addr, mem_wdata}, 0);
        else begin
          ew = wq.pop_front();
          check({mem_addr, mem_wdata} == ew, "R3 R4", "pixel write addr/data", {mem_addr, mem_wdata}, ew);
        end
      end
      if (m_valid && m_ready) begin
        if (rq.size() == 0) check(1'b0, "R7", "unexpected read word", m_data, 0);
        else begin
          er = rq.pop_front();
          check(m_data == er, "R7 R8", "read word", m_data, er);
        end
      end
      if (done) begin
        if (dq.size() == 0) check(1'b0, "R6 R9", "unexpected done", {done_x, done_y, done_w, done_h}, 0);
        else begin
          ed = dq.pop_front();
          check({done_x, done_y, done_w, done_h} == ed, "R1 R2 R6", "done rectangle",
                {done_x, done_y, done_w, done_h}, ed);
        end
      end
    end
  end

  task automatic start_xfer(bit rd, logic [31:0] pos, logic [31:0] size, bit exp_done);
    cx = int'(pos[9:0]);
    cy = int'(pos[24:16]);
    cw = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
    ch = (size[24:16] == 0) ? 512 : int'(size[24:16]);
    if (exp_done) dq.push_back({10'(cx), 9'(cy), 11'(cw), 10'(ch)});
    start = 1'b1; start_rd = rd; pos_in = pos; size_in = size;
    @(posedge clk); #5;
    start = 1'b0;
  endtask

  task automatic write_words(int n, int gap);
    for (int i = 0; i < n; i++) begin
      logic [15:0] lo, hi;
      bit hs;
      lo = 16'(seed * 71 + (2 * i) * 3 + 1);
      hi = 16'(seed * 71 + (2 * i + 1) * 3 + 1);
      if (2 * i < cw * ch)     wq.push_back({19'(pix_addr(2 * i)), lo});
      if (2 * i + 1 < cw * ch) wq.push_back({19'(pix_addr(2 * i + 1)), hi});
      s_valid = 1'b1;
      s_data  = {hi, lo};
      do begin
        @(negedge clk); hs = s_ready;
        @(posedge clk); #5;
      end while (!hs);
      s_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin @(posedge clk); #5; end
    end
  endtask

  task automatic read_words(int stall);
    int n, t;
    n = (cw * ch + 1) / 2;
    for (int i = 0; i < n; i++) begin
      logic [15:0] lo, hi;
      lo = peek(pix_addr(2 * i));
      hi = (2 * i + 1 < cw * ch) ? peek(pix_addr(2 * i + 1)) : 16'h0;
      rq.push_back({hi, lo});
    end
    t = 0;
    do begin @(negedge clk); t++; end while (!m_valid && t < 20);
    check(m_valid && (m_data == rq[0]), "R7", "preloaded first word", {31'h0, m_valid, m_data}, {32'h1, rq[0]});
    check(img_busy == 1'b1, "R7", "busy-image flag during read", 64'(img_busy), 1);
    @(posedge clk); #5;
    for (int i = 0; i < n; i++) begin
      bit hs;
      for (int s = 0; s < stall; s++) begin @(posedge clk); #5; end
      m_ready = 1'b1;
      do begin
        @(negedge clk); hs = m_valid;
        @(posedge clk); #5;
      end while (!hs);
      m_ready = 1'b0;
    end
  endtask

  task automatic finish_xfer(string req);
    for (int i = 0; i < 6; i++) begin @(posedge clk); #5; end
    check(wq.size() == 0, req, "pending pixel writes", 64'(wq.size()), 0);
    check(rq.size() == 0, req, "pending read words", 64'(rq.size()), 0);
    check(dq.size() == 0, req, "missing done pulse", 64'(dq.size()), 0);
    check(busy == 1'b0, req, "engine idle after transfer", 64'(busy), 0);
    check(img_busy == 1'b0, req, "busy-image flag after transfer", 64'(img_busy), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; start_rd = 1'b0; pos_in = '0; size_in = '0;
    s_valid = 1'b0; s_data = '0; m_ready = 1'b0; seed = 0;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({busy, s_ready, m_valid, mem_en, img_busy, anomaly, done} == 7'b0, "R10", "reset outputs",
          64'({busy, s_ready, m_valid, mem_en, img_busy, anomaly, done}), 0);
    @(posedge clk); #5;

    // R1 R3: 4x2 write at (10,5), back-to-back words
    seed = 1;
    start_xfer(1'b0, 32'h0005_000A, 32'h0002_0004, 1'b1);
    write_words(4, 0);
    finish_xfer("R1 R3");

    // R4 R5: 3x3 write at (1022,511), gaps between words, odd width
    seed = 2;
    start_xfer(1'b0, 32'h01FF_03FE, 32'h0003_0003, 1'b1);
    write_words(5, 2);
    finish_xfer("R4 R5");

    // R2 R4: width 1, height encoded 0 (512 rows) from row 100
    seed = 3;
    start_xfer(1'b0, 32'h0064_0003, 32'h0000_0001, 1'b1);
    write_words(256, 0);
    finish_xfer("R2 R4");

    // R7: 2x2 read of untouched area
    start_xfer(1'b1, 32'h0009_0007, 32'h0002_0002, 1'b1);
    read_words(0);
    finish_xfer("R7");

    // R8: 3x1 read-back of written pixels, consumer stalls
    start_xfer(1'b1, 32'h0005_000A, 32'h0001_0003, 1'b1);
    read_words(3);
    finish_xfer("R8");

    // R2: width encoded 0 (1024 columns) read
    start_xfer(1'b1, 32'h012C_0000, 32'h0001_0000, 1'b1);
    read_words(0);
    finish_xfer("R2");

    // R9: abort a write with a new read
    seed = 4;
    start_xfer(1'b0, 32'h0032_0032, 32'h0004_0004, 1'b0);
    write_words(2, 0);
    for (int i = 0; i < 3; i++) begin @(posedge clk); #5; end
    check(anomaly == 1'b0, "R9", "anomaly before abort", 64'(anomaly), 0);
    start_xfer(1'b1, 32'h001E_00C8, 32'h0001_0001, 1'b1);
    @(negedge clk);
    check(anomaly == 1'b1, "R9", "anomaly after abort", 64'(anomaly), 1);
    @(posedge clk); #5;
    read_words(0);
    finish_xfer("R9");
    check(anomaly == 1'b1, "R9", "anomaly stays set", 64'(anomaly), 1);

    summary();
    $finish;
  end

endmodule